// File: doc/BRIEF.md
# Word-Framed Serial Retiming Buffer

This block takes a serial stream of 16-bit audio words that arrives with one bit clock and sends the same words out, first in first out, on a second bit clock. The second clock needs no frequency or phase relation to the first. A word clock, sampled on the input bit clock, frames the stream. Each of its levels carries one word, so left and right samples share the path and alternate. A shifter gated by a bit counter collects the first sixteen bits of every half period. When the word clock next changes level, the collected word is copied into a holding register. That copy only happens if a complete word was collected.

A valid flag tells the output side that the holding register is loaded. The flag crosses into the output clock domain through a flop synchronizer. The first falling output edge that sees it loads an output shifter, and the output side raises an acknowledge. The acknowledge is synchronized back and closes the handshake. Each later falling output edge presents the next bit. Words therefore appear on the output about one word period after they arrived. Both clock domains are reset from one asynchronous active-low input, and each domain releases that reset through its own synchronizer.

Top module: `srb_retimer`

## Requirements
- R1: While `rst_n` is low, and after reset until the first word has been loaded, `out_sdata` is 0.
- R2: A word is captured most significant bit first. Its first bit is the one sampled on the `in_bclk` rising edge where `in_wclk` first shows a new level, and 16 consecutive rising edges fill it.
- R3: Bits that follow the sixteenth bit in the same word-clock half period are ignored and never reach the output.
- R4: A word-clock half period holding fewer than 16 bits delivers no word.
- R5: The `in_bclk` rising edge where `in_wclk` changes level copies the word collected in the ending half period into the holding register and raises the valid flag.
- R6: The output shifter loads the held word on the falling `out_bclk` edge SYNC_STAGES+1 edges after the transfer edge (the third edge by default). Right after that edge, `out_sdata` shows the most significant bit.
- R7: Each later falling `out_bclk` edge presents the next lower bit. After the least significant bit, `out_sdata` is 0 until the next load, and a new load cuts off any unfinished word.
- R8: Both word-clock levels carry words, and the words leave in the order they arrived.
- R9: The valid flag falls only after the acknowledge has come back. The holding register does not change until the handshake has closed.
- R10: The output clock may have any frequency and phase relative to `in_bclk`. Output timing follows R6 and R7 at each output rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| in_bclk | input | 1 | Input bit clock; data and word clock are sampled on its rising edge |
| in_wclk | input | 1 | Word clock; each level frames one word |
| in_sdata | input | 1 | Serial input data, most significant bit first |
| out_bclk | input | 1 | Output bit clock; the output changes on its falling edge |
| out_sdata | output | 1 | Serial output data, most significant bit first |

## Verification
A wrong bit count or a misplaced framing edge shifts or corrupts the whole word. It shows on `out_sdata` within the sixteen output edges that follow the next load. A fault in the synchronizer depth or the handshake moves the load to a different output edge. It can also drop or repeat a word. Either effect shows up as a bit mismatch within one word period. A stuck valid flag or acknowledge stalls every later word, so the output stays low where a word was expected.

// File: rtl/srb_pkg.sv
`timescale 1ns/1ps
package srb_pkg;

   // Handshake state of the holding register, kept in the input domain
   typedef enum logic [1:0] {
      HS_IDLE  = 2'd0,
      HS_OPEN  = 2'd1,
      HS_DRAIN = 2'd2
   } hs_state_e;

   localparam int unsigned SRB_MIN_STAGES = 2;

   // Width of a counter that must reach the value n
   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/srb_sync.sv
`timescale 1ns/1ps
module srb_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          FALL_EDGE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial begin
      if (STAGES < srb_pkg::SRB_MIN_STAGES)
         $error("srb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   generate
      if (FALL_EDGE) begin : g_fall
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
         end
      end else begin : g_rise
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/srb_capture.sv
`timescale 1ns/1ps
module srb_capture
   import srb_pkg::*;
#(
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wclk,
   input  logic              sdin,
   input  logic              ack_a,
   output logic [WORD_W-1:0] hold,
   output logic              vld
);
   localparam int unsigned CW = cnt_bits(WORD_W);

   logic              wclk_q;
   logic              in_word;
   logic [CW-1:0]     cnt;
   logic [WORD_W-1:0] shreg;
   logic [WORD_W-1:0] hold_q;
   logic              vld_q;
   logic              ack_s;
   logic              wedge;
   logic              full;
   logic              xfer;
   hs_state_e         st, st_nx;

   srb_sync #(.STAGES(SYNC_STAGES), .FALL_EDGE(1'b0)) u_ack_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (ack_a),
      .q    (ack_s)
   );

   assign wedge = wclk ^ wclk_q;
   assign full  = in_word && (cnt == CW'(WORD_W));
   assign xfer  = wedge && full && (st == HS_IDLE);

   always_comb begin
      st_nx = st;
      case (st)
         HS_IDLE:  if (xfer)   st_nx = HS_OPEN;
         HS_OPEN:  if (ack_s)  st_nx = HS_DRAIN;
         HS_DRAIN: if (!ack_s) st_nx = HS_IDLE;
         default:              st_nx = HS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wclk_q  <= 1'b0;
         in_word <= 1'b0;
         cnt     <= '0;
         shreg   <= '0;
         hold_q  <= '0;
         vld_q   <= 1'b0;
         st      <= HS_IDLE;
      end else begin
         wclk_q <= wclk;
         if (wedge) begin
            in_word <= 1'b1;
            cnt     <= CW'(1);
            shreg   <= {shreg[WORD_W-2:0], sdin};
         end else if (in_word && (cnt < CW'(WORD_W))) begin
            cnt   <= cnt + CW'(1);
            shreg <= {shreg[WORD_W-2:0], sdin};
         end
         if (xfer) hold_q <= shreg;
         st    <= st_nx;
         vld_q <= (st_nx == HS_OPEN);
      end
   end

   assign hold = hold_q;
   assign vld  = vld_q;

   p_vld_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> (vld_q && (hold_q == $past(shreg))));
   p_vld_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && !ack_s) |=> vld_q);
   p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st != HS_IDLE) |=> $stable(hold_q));
   p_shift_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !wedge) |=> $stable(shreg));
endmodule

// File: rtl/srb_replay.sv
`timescale 1ns/1ps
module srb_replay
   import srb_pkg::*;
#(
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_a,
   input  logic [WORD_W-1:0] hold_a,
   output logic              sdout,
   output logic              ack
);
   localparam int unsigned CW = cnt_bits(WORD_W);

   logic              vld_s;
   logic              ack_q;
   logic              load;
   logic [WORD_W-1:0] oreg;
   logic [CW-1:0]     left;

   srb_sync #(.STAGES(SYNC_STAGES), .FALL_EDGE(1'b1)) u_vld_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (vld_a),
      .q    (vld_s)
   );

   assign load = vld_s && !ack_q;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oreg  <= '0;
         left  <= '0;
         ack_q <= 1'b0;
      end else begin
         if (load) begin
            oreg <= hold_a;
            left <= CW'(WORD_W);
         end else begin
            oreg <= {oreg[WORD_W-2:0], 1'b0};
            if (left != '0) left <= left - CW'(1);
         end
         if (load)        ack_q <= 1'b1;
         else if (!vld_s) ack_q <= 1'b0;
      end
   end

   assign sdout = oreg[WORD_W-1];
   assign ack   = ack_q;

   p_load_msb_r6: assert property (@(negedge clk) disable iff (!rst_n)
      load |=> (sdout == $past(hold_a[WORD_W-1])));
   p_shift_next_r7: assert property (@(negedge clk) disable iff (!rst_n)
      (!load && (left > CW'(1))) |=> (sdout == $past(oreg[WORD_W-2])));
   p_idle_low_r7: assert property (@(negedge clk) disable iff (!rst_n)
      ((left == '0) && !load) |=> !sdout);
   p_ack_after_vld_r9: assert property (@(negedge clk) disable iff (!rst_n)
      $rose(ack_q) |-> $past(vld_s));
endmodule

// File: rtl/srb_retimer.sv
`timescale 1ns/1ps
module srb_retimer #(
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic rst_n,
   input  logic in_bclk,
   input  logic in_wclk,
   input  logic in_sdata,
   input  logic out_bclk,
   output logic out_sdata
);
   initial begin
      if (WORD_W < 2)
         $error("srb_retimer: WORD_W must be at least 2");
      if (SYNC_STAGES < srb_pkg::SRB_MIN_STAGES)
         $error("srb_retimer: SYNC_STAGES must be at least 2");
   end

   logic              rst_in_n;
   logic              rst_out_n;
   logic [WORD_W-1:0] hold;
   logic              vld;
   logic              ack;

   srb_sync #(.STAGES(2), .FALL_EDGE(1'b0)) u_rst_in (
      .clk  (in_bclk),
      .rst_n(rst_n),
      .d    (1'b1),
      .q    (rst_in_n)
   );

   srb_sync #(.STAGES(2), .FALL_EDGE(1'b1)) u_rst_out (
      .clk  (out_bclk),
      .rst_n(rst_n),
      .d    (1'b1),
      .q    (rst_out_n)
   );

   srb_capture #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_capture (
      .clk  (in_bclk),
      .rst_n(rst_in_n),
      .wclk (in_wclk),
      .sdin (in_sdata),
      .ack_a(ack),
      .hold (hold),
      .vld  (vld)
   );

   srb_replay #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_replay (
      .clk   (out_bclk),
      .rst_n (rst_out_n),
      .vld_a (vld),
      .hold_a(hold),
      .sdout (out_sdata),
      .ack   (ack)
   );

   p_reset_low_r1: assert property (@(negedge out_bclk)
      !rst_n |=> !out_sdata);
endmodule

// File: tb/tb_srb_retimer.sv
`timescale 1ns/1ps
module tb_srb_retimer;
   localparam int W    = 16;
   localparam int SYNC = 2;

   logic rst_n, in_bclk, in_wclk, in_sdata, out_bclk, out_sdata;

   srb_retimer #(.WORD_W(W), .SYNC_STAGES(SYNC)) dut (
      .rst_n    (rst_n),
      .in_bclk  (in_bclk),
      .in_wclk  (in_wclk),
      .in_sdata (in_sdata),
      .out_bclk (out_bclk),
      .out_sdata(out_sdata)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   string cur_req = "R1";
   real   out_half = 3.5;

   // reference model state
   logic         pend = 1'b0;
   int           pcnt = 0;
   logic [W-1:0] pword = '0;
   logic [W-1:0] exp_reg = '0;
   logic         prev_full = 1'b0;
   logic [W-1:0] prev_word = '0;
   logic         lvl = 1'b0;

   initial begin in_bclk = 1'b0; forever #4 in_bclk = ~in_bclk; end
   initial begin out_bclk = 1'b0; #1.25; forever #(out_half) out_bclk = ~out_bclk; end

   task automatic chk(input logic act, input logic exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s out_sdata=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
   endtask

   // Output side of the model: load SYNC+1 falling edges after a transfer (R6), then shift (R7)
   always @(negedge out_bclk) begin
      logic ld;
      ld = 1'b0;
      if (pend) begin
         pcnt++;
         if (pcnt == SYNC + 1) begin ld = 1'b1; pend = 1'b0; end
      end
      if (ld) exp_reg = pword;
      else    exp_reg = exp_reg << 1;
   end

   // Compare on every output clock, midway between falling edges
   always @(posedge out_bclk) begin
      if ($time > 2) chk(out_sdata, exp_reg[W-1], cur_req);
   end

   // One word-clock half period: nbits bits, the word MSB first, then random filler (R3)
   task automatic send_half(input logic l, input logic [W-1:0] w, input int nbits);
      for (int b = 0; b < nbits; b++) begin
         @(negedge in_bclk);
         in_wclk  = l;
         in_sdata = (b < W) ? w[W-1-b] : 1'($urandom_range(0, 1));
         if (b == 0) begin
            @(posedge in_bclk);
            // R5: the level change ends the previous half; a full word transfers (R4 otherwise)
            if (prev_full) begin
               pword = prev_word;
               pcnt  = 0;
               pend  = 1'b1;
            end
         end
      end
      prev_full = (nbits >= W);
      prev_word = w;
   endtask

   logic [W-1:0] pat [6] = '{16'hA5C3, 16'h8001, 16'hFFFF, 16'h0000, 16'h7FFE, 16'h1357};

   initial begin
      #(200000 * 8);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired at %0t", $time);
      summary();
      $finish;
   end

   initial begin
      rst_n    = 1'b1;
      in_wclk  = 1'b0;
      in_sdata = 1'b0;
      #1 rst_n = 1'b0;
      repeat (6) @(negedge in_bclk);
      chk(out_sdata, 1'b0, "R1 in reset");
      rst_n = 1'b1;
      repeat (10) @(negedge in_bclk);
      chk(out_sdata, 1'b0, "R1 after reset");

      // R2 R3 R5 R6 R7 R8 R9: full words on alternating levels, filler after bit 16
      cur_req = "R2 R3 R5 R6 R7 R8 R9";
      lvl = 1'b1;
      foreach (pat[i]) begin
         send_half(lvl, pat[i], 32);
         lvl = ~lvl;
      end

      // R4: short halves deliver nothing
      cur_req = "R4";
      send_half(lvl, 16'h1234, 10); lvl = ~lvl;
      send_half(lvl, 16'hBEEF, 32); lvl = ~lvl;
      send_half(lvl, 16'hFACE, 15); lvl = ~lvl;
      send_half(lvl, 16'h0F0F, 24); lvl = ~lvl;
      send_half(lvl, 16'hC001, 20); lvl = ~lvl;

      // R10: slower unrelated output clock, back-to-back 16-bit halves (R7 cut-off)
      cur_req = "R10 R7";
      out_half = 4.6;
      for (int k = 0; k < 12; k++) begin
         send_half(lvl, 16'($urandom), (k % 3 == 0) ? 16 : 16 + (k % 5));
         lvl = ~lvl;
      end
      send_half(lvl, 16'h0000, 24);
      repeat (60) @(negedge out_bclk);
      chk(out_sdata, 1'b0, "R7 idle after last word");

      summary();
      $finish;
   end
endmodule